// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns one configuration-space request into a local 32-bit memory-mapped access. A request names a bus, a device, a function, a byte offset, an access size of 1, 2 or 4 bytes, a direction and write data. From these the block builds the configuration address and loads a window register whose upper bits extend that address. It then makes one or two dword accesses on the local bus. A read is followed by lane extraction. A sub-word write is a read-modify-write of the dword.

Bus number zero selects a Type 0 access. The target slot is a one-hot bit at position device+16. The bits of that value that fall under the window mask go into the window register. The remaining bits stay in the address. Any other bus number selects a Type 1 access. In that case bus, device and function are packed into the address and the window register carries the Type 1 selector. Requests that cannot be mapped are refused at once, with no bus traffic.

Both host-side channels use valid/ready. The request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The response is held stable, with `rsp_valid` high, until a clock edge where `rsp_ready` is high. The local bus side has one transaction outstanding at a time. `bus_req` and `bus_addr` hold until a one-cycle `bus_ack` arrives, and `bus_ack` carries `bus_rdata` and `bus_err` with it.

Top module: `cfg_xlate`

## Requirements
- R1: With bus number 0, let the one-hot slot bit be 1<<(dev+16). The window register becomes 0x2 OR (one-hot AND 0xFC000000). The access address is 0x0C000000 OR (one-hot AND NOT 0xFC000000) OR func<<8 OR (offset with bits 1:0 cleared).
- R2: With a nonzero bus number, the window register becomes 0x3. The address is 0x0C000000 OR bus<<16 OR dev<<11 OR func<<8 OR (offset with bits 1:0 cleared).
- R3: A bus-0 request with a device number of 16 or more is refused.
- R4: While `card_mode` is high, any device number other than 0 is refused on every bus. Device 0 is served normally.
- R5: A size other than 1, 2 or 4 is refused.
- R6: For a refused request, `rsp_valid` is high in the cycle after acceptance with `rsp_err`=1. No local bus access takes place and the window register keeps its value.
- R7: Read data is the fetched dword shifted right by 8*(offset mod 4) and then cut to the size: 8 bits for size 1, 16 bits for size 2, with the upper bits zero. `rsp_err` is 0.
- R8: A 1- or 2-byte write first reads the dword. It then writes back the dword with the addressed lanes, starting at lane (offset mod 4) and going no higher than lane 3, replaced by the low bytes of the write data.
- R9: A 4-byte write probes the dword with a read and then writes the write data unchanged, making two bus accesses in total.
- R10: If the local bus reports an error on the probing read, the response has `rsp_err`=1 and `rsp_data`=0xFFFFFFFF, and no write access follows.
- R11: After reset, `req_ready`=1, `busy`=0, `rsp_valid`=0, `bus_req`=0 and the window holds 0x2. From acceptance until the response is taken, `busy`=1 and `req_ready`=0, and the window register does not change.
- R12: While `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` and `rsp_err` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_mode | input | 1 | Single-slot mode: only device 0 is reachable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_data | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Request refused or bus error |
| busy | output | 1 | A request is in progress |
| win_reg | output | 32 | Window control register |
| bus_req | output | 1 | Local bus access request |
| bus_we | output | 1 | Local bus write enable |
| bus_addr | output | 32 | Local bus dword address |
| bus_wdata | output | 32 | Local bus write data |
| bus_ack | input | 1 | Local bus completion pulse |
| bus_rdata | input | 32 | Local bus read data, valid with bus_ack |
| bus_err | input | 1 | Local bus error, valid with bus_ack |

## Verification
The window register changes on the acceptance edge, so the bench checks it at the falling edge that follows. A refused request must show `rsp_valid` at that same falling edge. For a read, the response is due one cycle after the read `bus_ack`. For a write, the second access starts one cycle after the read `bus_ack`, and the response follows one cycle after the write acknowledge. The bench waits for `rsp_valid` at falling edges and checks data and flags there. It compares bus traffic through counters that its bus model updates when it acknowledges. Response stability is checked by holding `rsp_ready` low for several cycles and sampling on each of them.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_RSP  = 2'd3
  } cfgx_st_e;
endpackage

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen #(
  parameter int          BUS_W    = 8,
  parameter int          DEV_W    = 5,
  parameter int          FN_W     = 3,
  parameter int          OFF_W    = 8,
  parameter int          SZ_W     = 3,
  parameter int          SLOTS    = 16,
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [31:0] SEL_T0   = 32'h0000_0002,
  parameter logic [31:0] SEL_T1   = 32'h0000_0003
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  input  logic             card_mode,
  output logic             rej,
  output logic [31:0]      addr,
  output logic [31:0]      win
);
  localparam int SH_W = 7;

  logic        type0;
  logic        size_ok;
  logic        dev_ok;
  logic [31:0] slot_oh;
  logic [31:0] off_al;

  always_comb begin
    type0   = (bus == '0);
    size_ok = (size == SZ_W'(1)) || (size == SZ_W'(2)) || (size == SZ_W'(4));
    dev_ok  = card_mode ? (dev == '0) : 1'b1;
    if (type0 && (int'(dev) >= SLOTS)) dev_ok = 1'b0;
    rej     = !size_ok || !dev_ok;
    slot_oh = 32'd1 << (SH_W'(dev) + SH_W'(16));
    off_al  = 32'(off) & ~32'd3;
    if (type0) begin
      win  = SEL_T0 | (slot_oh & WIN_MASK);
      addr = CFG_BASE | (slot_oh & ~WIN_MASK) | (32'(fn) << 8) | off_al;
    end else begin
      win  = SEL_T1;
      addr = CFG_BASE | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | off_al;
    end
  end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane #(
  parameter int SZ_W = 3
) (
  input  logic [31:0]     word,
  input  logic [1:0]      off_lo,
  input  logic [SZ_W-1:0] size,
  input  logic [31:0]     wdata,
  output logic [31:0]     rd_ext,
  output logic [31:0]     wr_merged
);
  localparam int LANES = 4;

  logic [4:0]       sh;
  logic [31:0]      shifted;
  logic [31:0]      ins;
  logic [LANES-1:0] be;

  always_comb begin
    sh      = {off_lo, 3'b000};
    shifted = word >> sh;
    ins     = wdata << sh;
    if (size == SZ_W'(1))      rd_ext = {24'd0, shifted[7:0]};
    else if (size == SZ_W'(2)) rd_ext = {16'd0, shifted[15:0]};
    else                       rd_ext = shifted;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      be[b] = (4'(b) >= {2'b00, off_lo}) && (4'(b) < ({2'b00, off_lo} + 4'(size)));
      if (size == SZ_W'(4))
        wr_merged[8*b +: 8] = wdata[8*b +: 8];
      else
        wr_merged[8*b +: 8] = be[b] ? ins[8*b +: 8] : word[8*b +: 8];
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter int          BUS_W    = 8,
  parameter int          DEV_W    = 5,
  parameter int          FN_W     = 3,
  parameter int          OFF_W    = 8,
  parameter int          SZ_W     = 3,
  parameter int          SLOTS    = 16,
  parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
  parameter logic [31:0] SEL_T0   = 32'h0000_0002,
  parameter logic [31:0] SEL_T1   = 32'h0000_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [FN_W-1:0]  req_func,
  input  logic [OFF_W-1:0] req_off,
  input  logic [SZ_W-1:0]  req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  output logic             rsp_err,
  output logic             busy,
  output logic [31:0]      win_reg,
  output logic             bus_req,
  output logic             bus_we,
  output logic [31:0]      bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata,
  input  logic             bus_err
);
  import cfgx_pkg::*;

  cfgx_st_e        st;
  logic            q_write;
  logic [SZ_W-1:0] q_size;
  logic [1:0]      q_offlo;
  logic [31:0]     q_wdata;
  logic            dec_rej;
  logic [31:0]     dec_addr;
  logic [31:0]     dec_win;
  logic [31:0]     rd_ext;
  logic [31:0]     wr_merged;
  logic            accept;

  cfgx_addr_gen #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .SZ_W(SZ_W),
    .SLOTS(SLOTS), .CFG_BASE(CFG_BASE), .WIN_MASK(WIN_MASK),
    .SEL_T0(SEL_T0), .SEL_T1(SEL_T1)
  ) u_addr (
    .bus(req_bus), .dev(req_dev), .fn(req_func), .off(req_off), .size(req_size),
    .card_mode(card_mode), .rej(dec_rej), .addr(dec_addr), .win(dec_win)
  );

  cfgx_lane #(.SZ_W(SZ_W)) u_lane (
    .word(bus_rdata), .off_lo(q_offlo), .size(q_size), .wdata(q_wdata),
    .rd_ext(rd_ext), .wr_merged(wr_merged)
  );

  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign bus_req   = (st == ST_RD) || (st == ST_WR);
  assign bus_we    = (st == ST_WR);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q_write   <= 1'b0;
      q_size    <= '0;
      q_offlo   <= 2'b00;
      q_wdata   <= '0;
      win_reg   <= SEL_T0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_size  <= req_size;
          q_offlo <= req_off[1:0];
          q_wdata <= req_wdata;
          if (dec_rej) begin
            rsp_err  <= 1'b1;
            rsp_data <= '0;
            st       <= ST_RSP;
          end else begin
            win_reg  <= dec_win;
            bus_addr <= dec_addr;
            st       <= ST_RD;
          end
        end
        ST_RD: if (bus_ack) begin
          if (bus_err) begin
            rsp_err  <= 1'b1;
            rsp_data <= '1;
            st       <= ST_RSP;
          end else if (q_write) begin
            bus_wdata <= wr_merged;
            st        <= ST_WR;
          end else begin
            rsp_err  <= 1'b0;
            rsp_data <= rd_ext;
            st       <= ST_RSP;
          end
        end
        ST_WR: if (bus_ack) begin
          rsp_err  <= bus_err;
          rsp_data <= '0;
          st       <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_rej) |=> (rsp_valid && rsp_err && !bus_req && $stable(win_reg))); // R6
  AST_TYPE0_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_rej && req_bus == '0) |=> ((win_reg & ~WIN_MASK) == SEL_T0)); // R1
  AST_TYPE1_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_rej && req_bus != '0) |=> (win_reg == SEL_T1)); // R2
  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(win_reg)); // R11
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr))); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R12
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && bus_ack && bus_err) |=> (rsp_valid && rsp_err && rsp_data == 32'hFFFF_FFFF)); // R10
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && bus_ack && bus_err) |=> !bus_req); // R10
endmodule

// File: tb/tb_cfg_xlate.sv
module tb_cfg_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'h8765_4321;
  localparam int WDOG = 20000;

  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [7:0]  off;
    logic [2:0]  sz;
    logic        we;
    logic [31:0] wd;
    logic        err;
    logic [31:0] addr;
    logic [31:0] win;
    logic [31:0] dat;
    logic [1:0]  nacc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 5'd0,  3'd0, 8'h00, 3'd4, 1'b0, 32'h0,         1'b0, 32'h0C01_0000, 32'h0000_0002, 32'h8765_4321, 2'd1},
    '{8'd0, 5'd3,  3'd2, 8'h0D, 3'd1, 1'b0, 32'h0,         1'b0, 32'h0C08_020C, 32'h0000_0002, 32'h0000_0043, 2'd1},
    '{8'd0, 5'd12, 3'd1, 8'h06, 3'd2, 1'b0, 32'h0,         1'b0, 32'h0C00_0104, 32'h1000_0002, 32'h0000_8765, 2'd1},
    '{8'd5, 5'd7,  3'd3, 8'h43, 3'd1, 1'b0, 32'h0,         1'b0, 32'h0C05_3B40, 32'h0000_0003, 32'h0000_0087, 2'd1},
    '{8'd2, 5'd1,  3'd0, 8'h10, 3'd4, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0C02_0810, 32'h0000_0003, 32'hDEAD_BEEF, 2'd2},
    '{8'd0, 5'd1,  3'd0, 8'h05, 3'd1, 1'b1, 32'h0000_00AB, 1'b0, 32'h0C02_0004, 32'h0000_0002, 32'h8765_AB21, 2'd2},
    '{8'd0, 5'd15, 3'd7, 8'h0E, 3'd2, 1'b1, 32'h0000_1234, 1'b0, 32'h0C00_070C, 32'h8000_0002, 32'h1234_4321, 2'd2},
    '{8'd0, 5'd0,  3'd0, 8'h00, 3'd3, 1'b0, 32'h0,         1'b1, 32'h0,         32'h8000_0002, 32'h0,         2'd0},
    '{8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0,         1'b1, 32'h0,         32'h8000_0002, 32'h0,         2'd0},
    '{8'd1, 5'd0,  3'd0, 8'h00, 3'd0, 1'b1, 32'h5555_5555, 1'b1, 32'h0,         32'h8000_0002, 32'h0,         2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0;
  logic [7:0] req_off = '0;
  logic [2:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic rsp_err;
  logic busy;
  logic [31:0] win_reg;
  logic bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic bus_err = 1'b0;

  logic inj_err = 1'b0;
  int lat = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [31:0] rd_addr_log = '0;
  logic [31:0] wr_addr_log = '0;
  logic [31:0] wr_data_log = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_xlate dut (
    .clk(clk), .rst_n(rst_n), .card_mode(card_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .busy(busy), .win_reg(win_reg),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // Local bus model: acknowledges after two request cycles, one access at a time.
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      lat     <= 0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (lat == 1) begin
          bus_ack   <= 1'b1;
          lat       <= 0;
          bus_err   <= inj_err;
          bus_rdata <= PAT;
          if (bus_we) begin
            n_wr        <= n_wr + 1;
            wr_addr_log <= bus_addr;
            wr_data_log <= bus_wdata;
          end else begin
            n_rd        <= n_rd + 1;
            rd_addr_log <= bus_addr;
          end
        end else begin
          lat <= lat + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One request: drive, accept, wait for the response, optionally hold rsp_ready low.
  task automatic xfer(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                      input logic [7:0] o, input logic [2:0] s, input logic w,
                      input logic [31:0] wd, input int hold,
                      output logic [31:0] data, output logic err,
                      output logic [31:0] win_after, output logic first_valid,
                      output int acc);
    int rd0, wr0;
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    req_bus = b; req_dev = d; req_func = f; req_off = o; req_size = s;
    req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid   = 1'b0;
    win_after   = win_reg;
    first_valid = rsp_valid;
    chk("R11 busy after accept", {30'd0, busy, req_ready}, 32'd2);
    while (!rsp_valid) @(negedge clk);
    data = rsp_data;
    err  = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R12 valid held", {31'd0, rsp_valid}, 32'd1);
      chk("R12 data held", rsp_data, data);
      chk("R12 flag held", {31'd0, rsp_err}, {31'd0, err});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    acc = (n_rd - rd0) + (n_wr - wr0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=response");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] data, win_a;
    logic err, fv;
    int acc, wr0;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: state after reset
    chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 reset bus_req", {31'd0, bus_req}, 32'd0);
    chk("R11 reset window", win_reg, 32'h0000_0002);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].bus, VECS[i].dev, VECS[i].fn, VECS[i].off, VECS[i].sz, VECS[i].we,
           VECS[i].wd, 0, data, err, win_a, fv, acc);
      chk("R3/R5 error flag", {31'd0, err}, {31'd0, VECS[i].err});
      chk("R1/R2/R6 window", win_a, VECS[i].win);
      chk("R6/R9 access count", acc, {30'd0, VECS[i].nacc});
      if (VECS[i].err) begin
        chk("R6 response next cycle", {31'd0, fv}, 32'd1);
      end else begin
        chk("R1/R2 probe address", rd_addr_log, VECS[i].addr);
        if (VECS[i].we) begin
          chk("R8/R9 write address", wr_addr_log, VECS[i].addr);
          chk("R8/R9 written dword", wr_data_log, VECS[i].dat);
        end else begin
          chk("R7 read data", data, VECS[i].dat);
        end
      end
    end

    // R4: single-slot mode
    card_mode = 1'b1;
    xfer(8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, 0, data, err, win_a, fv, acc);
    chk("R4 dev1 refused", {31'd0, err}, 32'd1);
    chk("R4 dev1 no access", acc, 32'd0);
    xfer(8'd3, 5'd2, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, 0, data, err, win_a, fv, acc);
    chk("R4 type1 dev2 refused", {31'd0, err}, 32'd1);
    xfer(8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, 0, data, err, win_a, fv, acc);
    chk("R4 dev0 served", {31'd0, err}, 32'd0);
    chk("R4 dev0 data", data, PAT);
    chk("R4 dev0 address", rd_addr_log, 32'h0C01_0000);
    card_mode = 1'b0;

    // R10: bus error on the probe
    inj_err = 1'b1;
    xfer(8'd1, 5'd0, 3'd0, 8'h00, 3'd4, 1'b0, 32'h0, 0, data, err, win_a, fv, acc);
    chk("R10 read error flag", {31'd0, err}, 32'd1);
    chk("R10 read all ones", data, 32'hFFFF_FFFF);
    chk("R10 read one access", acc, 32'd1);
    wr0 = n_wr;
    xfer(8'd0, 5'd2, 3'd0, 8'h01, 3'd1, 1'b1, 32'h0000_0077, 0, data, err, win_a, fv, acc);
    chk("R10 write error flag", {31'd0, err}, 32'd1);
    chk("R10 write skipped", n_wr - wr0, 32'd0);
    inj_err = 1'b0;

    // R12: response held under back-pressure
    xfer(8'd0, 5'd4, 3'd0, 8'h02, 3'd2, 1'b0, 32'h0, 4, data, err, win_a, fv, acc);
    chk("R12 held read data", data, 32'h0000_8765);
    @(negedge clk);
    chk("R11 idle after response", {31'd0, req_ready}, 32'd1);

    summary();
    $finish;
  end
endmodule